// File: doc/BRIEF.md
# Non-volatile data array write controller

This block fronts a 512-byte non-volatile data array that sits in the low part of a CPU data space. The CPU reads the array like ordinary memory over a byte-wide bus. Each array read costs one wait cycle. A byte write to the array starts a self-timed erase/write cycle at that location. The array is a behavioural register array, and the length of the erase/write cycle is a parameter counted in clock cycles. A separate 8-bit control/status register sets write protection, standby, a verify flag, the end-of-write interrupt and a row-parallel programming mode. In that mode up to sixteen bytes of one row are collected in latches and then programmed together.

Software first sets the write enable bit, then writes bytes. It either polls the busy bit or waits for the end-of-write interrupt. The interrupt output is shared with an external interrupt input. Enabling the array interrupt disconnects that input. After any programming cycle ends, and after leaving standby, the array refuses accesses for a fixed recovery time.

Top module: `nvm_write_ctrl`

## Requirements
- R1: After reset the control register reads 00h, every array byte reads 00h (erased), and `irq_out` follows `ext_irq_in`.
- R2: A byte read inside 000h–1FFh holds `bus_wait` high for exactly its first cycle. The data appears on `bus_rdata` in the second cycle. Reads outside the array and reads with `bus_word` high never raise `bus_wait`.
- R3: With write enable (control bit 0) set, a byte write starts a cycle. Busy (control bit 1) rises on the next cycle and stays high for PROG_CYCLES cycles. Afterwards the location reads back the written byte in full, replacing the old value.
- R4: While write enable is 0, array writes change nothing and do not raise busy. Writes with `bus_word` high are ignored at all times.
- R5: While busy is 1, array writes are dropped and array reads return 00h. A control write cannot clear busy.
- R6: While parallel enable (bit 2) is 1, byte writes are stored into a 16-entry row latch, in any order, and do not start a cycle. Writing 1 to parallel start (bit 3) programs every latched byte in one cycle and leaves the unlatched bytes of the row unchanged.
- R7: Parallel start is accepted only if parallel enable is already 1 before that control write. While a cycle runs, bits 2 and 3 both read 1. Both clear when the cycle ends.
- R8: Array reads while parallel enable is 1 return 00h. Clearing parallel enable and then reading the array discards all latched bytes, so a later parallel start programs nothing.
- R9: While bytes are latched, a write to an address in a different row (address bits 8..4) is ignored and the latch keeps its row.
- R10: With interrupt enable (bit 4) set, `irq_out` ignores `ext_irq_in` and pulses high for exactly one cycle after each cycle ends. With bit 4 clear, `irq_out` equals `ext_irq_in`.
- R11: For 6 cycles after busy falls, array writes are dropped and array reads return 00h. Parallel start is refused during the same window.
- R12: While standby (bit 5) is 1, array writes are dropped and reads return 00h. Clearing standby opens the same 6-cycle recovery window.
- R13: Verify (bit 6) is read/write storage that does not affect array data. Bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Data-space byte address |
| bus_rd | input | 1 | Read strobe, held until `bus_wait` is low |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_word | input | 1 | Marks a 16-bit access, which the array ignores |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle after the wait cycle |
| bus_wait | output | 1 | Wait request for array reads |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control/status register value |
| ext_irq_in | input | 1 | Shared external interrupt input |
| irq_out | output | 1 | Interrupt request to the interrupt unit |

## Verification
The bench targets these corner cases:
- Reads issued in the first cycle after busy falls, and writes a few cycles later. A design without the recovery window would return stale data here or start a new cycle.
- A parallel start written while parallel enable was still 0. A design that accepted it would raise busy.
- A dummy read after parallel enable is cleared, followed by an empty parallel cycle over a byte programmed earlier. A design that kept the latches would overwrite that byte.
- A foreign-row write between latched bytes. A design that accepted it would corrupt the row or the other address.
- A high external interrupt held across an interrupt-enabled cycle. Any leak of the external level, or a pulse longer than one cycle, shows on the cycle-by-cycle comparison of all outputs against the bench model.

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl #(
  parameter int ADDR_W         = 16,
  parameter int ARRAY_BYTES    = 512,
  parameter int ROW_BYTES      = 16,
  parameter int PROG_CYCLES    = 16,
  parameter int RECOVER_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_wait,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              ext_irq_in,
  output logic              irq_out
);
  localparam int IDX_W  = $clog2(ARRAY_BYTES);
  localparam int ROW_W  = $clog2(ROW_BYTES);
  localparam int LINE_W = IDX_W - ROW_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);
  localparam int REC_W  = $clog2(RECOVER_CYCLES + 1);

  logic [7:0] mem [ARRAY_BYTES];
  logic [7:0] rowbuf [ROW_BYTES];
  logic [ROW_BYTES-1:0] lat_vld;
  logic [LINE_W-1:0] lat_row;

  logic wen, busy, pen, pst, ien, stby, ver, done_q, rd_pend;
  logic [7:0] rd_q, p_data;
  logic [IDX_W-1:0] p_addr;
  logic [CNT_W-1:0] cnt;
  logic [REC_W-1:0] rec;

  wire [IDX_W-1:0]  idx      = bus_addr[IDX_W-1:0];
  wire [LINE_W-1:0] line     = idx[IDX_W-1:ROW_W];
  wire              hit      = bus_addr < ADDR_W'(ARRAY_BYTES);
  wire              byte_acc = hit & ~bus_word;
  wire              quiet    = (rec == '0) & ~stby;
  wire              rd_start = bus_rd & byte_acc & ~rd_pend;
  wire              rd_block = busy | pen | ~quiet;
  wire              wr_ok    = bus_wr & byte_acc & wen & ~busy & quiet;
  wire              row_ok   = (lat_vld == '0) | (lat_row == line);
  wire              go_single = wr_ok & ~pen;
  wire              go_par   = ctl_wr & ctl_wdata[3] & pen & ~busy & quiet;
  wire              finish   = busy & (cnt == '0);
  wire              unused_ctl_bits = ctl_wdata[7] ^ ctl_wdata[1];

  assign bus_wait  = rd_start;
  assign bus_rdata = rd_pend ? rd_q : 8'h00;
  assign ctl_rdata = {1'b0, ver, stby, ien, pst, pen, busy, wen};
  assign irq_out   = ien ? done_q : ext_irq_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {ver, stby, ien, pst, pen, busy, wen, done_q} <= '0;
      cnt    <= '0;
      rec    <= '0;
      p_addr <= '0;
      p_data <= '0;
    end else begin
      done_q <= finish;
      if (rec != '0) rec <= rec - 1'b1;
      if (ctl_wr) begin
        ver  <= ctl_wdata[6];
        stby <= ctl_wdata[5];
        ien  <= ctl_wdata[4];
        wen  <= ctl_wdata[0];
        if (stby && !ctl_wdata[5]) rec <= REC_W'(RECOVER_CYCLES);
        if (!busy) pen <= ctl_wdata[2] | go_par;
      end
      if (go_par || go_single) begin
        busy <= 1'b1;
        pst  <= go_par;
        cnt  <= CNT_W'(PROG_CYCLES - 1);
      end
      if (go_single) begin
        p_addr <= idx;
        p_data <= bus_wdata;
      end
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          pen  <= 1'b0;
          pst  <= 1'b0;
          rec  <= REC_W'(RECOVER_CYCLES);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lat_vld <= '0;
      lat_row <= '0;
    end else if (finish || (rd_start && !pen)) begin
      lat_vld <= '0;
    end else if (wr_ok && pen && row_ok) begin
      lat_vld[idx[ROW_W-1:0]] <= 1'b1;
      lat_row <= line;
    end

  always_ff @(posedge clk)
    if (wr_ok && pen && row_ok) rowbuf[idx[ROW_W-1:0]] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'h00;
    end else if (finish) begin
      if (pst) begin
        for (int k = 0; k < ROW_BYTES; k++)
          if (lat_vld[k]) mem[{lat_row, ROW_W'(k)}] <= rowbuf[k];
      end else begin
        mem[p_addr] <= p_data;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_q    <= 8'h00;
    end else begin
      rd_pend <= rd_start;
      if (rd_start) rd_q <= rd_block ? 8'h00 : mem[idx];
    end

  // R2
  one_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |=> !bus_wait);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_single |=> busy);

  // R5
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> (bus_rdata == 8'h00));

  // R7
  par_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pst) |-> $past(pen));

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && ien && !ctl_wr) |=> irq_out);

  // R11
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec != '0) |=> !$rose(busy));
endmodule

// File: tb/test_nvm_write_ctrl.sv
module test_nvm_write_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 20;
  localparam int REC  = 6;

  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0, bus_word = 0, ctl_wr = 0, ext_irq_in = 0;
  logic [7:0] bus_wdata = '0, ctl_wdata = '0;
  logic [7:0] bus_rdata, ctl_rdata;
  logic bus_wait, irq_out;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_write_ctrl #(.PROG_CYCLES(PROG), .RECOVER_CYCLES(REC)) i_nvm_write_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ext_irq_in(ext_irq_in), .irq_out(irq_out));

  // reference model
  int mem_m [512];
  int lat [int];
  int lat_row = 0, m_cnt = 0, m_rec = 0, m_paddr = 0, m_pdata = 0, m_rdq = 0;
  bit m_wen, m_busy, m_pen, m_pst, m_ien, m_stby, m_ver, m_done, m_rdp;

  always @(posedge clk) begin : model
    bit hit, n_busy, n_pen, n_pst, n_done, n_rdp;
    int a, n_cnt, n_rec, n_rdq;
    if (!rst_n) begin
      foreach (mem_m[i]) mem_m[i] = 0;
      lat.delete();
      {m_wen, m_busy, m_pen, m_pst, m_ien, m_stby, m_ver, m_done, m_rdp} = '0;
      m_cnt = 0; m_rec = 0; m_rdq = 0;
    end else begin
      hit = bus_addr < 512;
      a = bus_addr % 512;
      n_busy = m_busy; n_pen = m_pen; n_pst = m_pst; n_cnt = m_cnt;
      n_rec = (m_rec > 0) ? m_rec - 1 : 0;
      n_done = 0; n_rdp = 0; n_rdq = m_rdq;
      if (!m_rdp && bus_rd && hit && !bus_word) begin
        n_rdp = 1;
        n_rdq = (m_busy || m_pen || m_stby || m_rec > 0) ? 0 : mem_m[a];
        if (!m_pen) lat.delete();
      end
      if (bus_wr && hit && !bus_word && m_wen && !m_busy && !m_stby && m_rec == 0) begin
        if (m_pen) begin
          if (lat.num() == 0 || lat_row == a / 16) begin
            lat[a % 16] = bus_wdata;
            lat_row = a / 16;
          end
        end else begin
          n_busy = 1; n_cnt = PROG - 1; m_paddr = a; m_pdata = bus_wdata;
        end
      end
      if (ctl_wr) begin
        m_ver = ctl_wdata[6]; m_ien = ctl_wdata[4]; m_wen = ctl_wdata[0];
        if (m_stby && !ctl_wdata[5]) n_rec = REC;
        if (!m_busy) begin
          n_pen = ctl_wdata[2];
          if (ctl_wdata[3] && m_pen && !m_stby && m_rec == 0) begin
            n_pst = 1; n_pen = 1; n_busy = 1; n_cnt = PROG - 1;
          end
        end
        m_stby = ctl_wdata[5];
      end
      if (m_busy) begin
        if (m_cnt == 0) begin
          if (m_pst) foreach (lat[k]) mem_m[lat_row * 16 + k] = lat[k];
          else mem_m[m_paddr] = m_pdata;
          lat.delete();
          n_busy = 0; n_pen = 0; n_pst = 0; n_done = 1; n_rec = REC;
        end else n_cnt = m_cnt - 1;
      end
      m_busy = n_busy; m_pen = n_pen; m_pst = n_pst; m_cnt = n_cnt; m_rec = n_rec;
      m_done = n_done; m_rdp = n_rdp; m_rdq = n_rdq;
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check("R2 bus_wait vs model", bus_wait,
            int'(bus_rd && bus_addr < 512 && !bus_word && !m_rdp));
      check("R3 bus_rdata vs model", bus_rdata, m_rdp ? m_rdq : 0);
      check("R5 ctl_rdata vs model", ctl_rdata,
            {1'b0, m_ver, m_stby, m_ien, m_pst, m_pen, m_busy, m_wen});
      check("R10 irq_out vs model", irq_out, m_ien ? m_done : ext_irq_in);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic bus_write(int a, logic [7:0] d, bit word = 0);
    @(negedge clk); bus_wr = 1; bus_addr = 16'(a); bus_wdata = d; bus_word = word;
    @(negedge clk); bus_wr = 0; bus_word = 0;
  endtask

  task automatic bus_read(int a, output int d, output int w0, input bit word = 0);
    @(negedge clk); bus_rd = 1; bus_addr = 16'(a); bus_word = word;
    #2 w0 = bus_wait;
    @(negedge clk); #1 d = bus_rdata; bus_rd = 0; bus_word = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    #2;
    while (ctl_rdata[1]) begin n++; @(negedge clk); #2; end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int d, w, n, hi;
    idle(3);
    @(negedge clk); rst_n = 1;
    // R1
    check("R1 ctl after reset", ctl_rdata, 8'h00);
    ext_irq_in = 1; #1 check("R1 irq follows ext", irq_out, 1);
    ext_irq_in = 0;
    bus_read(9'h105, d, w); check("R1 erased byte", d, 0);
    // R2
    check("R2 wait in first cycle", w, 1);
    bus_read(16'h0300, d, w); check("R2 no wait outside array", w, 0);
    bus_read(9'h010, d, w, 1); check("R2 no wait word read", w, 0);
    // R4
    bus_write(9'h010, 8'hA5); check("R4 no busy with wen 0", ctl_rdata[1], 0);
    bus_read(9'h010, d, w); check("R4 byte unchanged wen 0", d, 0);
    ctl_write(8'h01);
    bus_write(9'h012, 8'hEE, 1); check("R4 word write no busy", ctl_rdata[1], 0);
    bus_read(9'h012, d, w); check("R4 word write ignored", d, 0);
    // R3 / R5 / R11
    bus_write(9'h010, 8'hA5); check("R3 busy next cycle", ctl_rdata[1], 1);
    bus_read(9'h010, d, w); check("R5 read while busy", d, 0);
    bus_write(9'h011, 8'h77);
    ctl_write(8'h01); check("R5 busy not clearable", ctl_rdata[1], 1);
    wait_idle(n);
    bus_read(9'h010, d, w); check("R11 read in recovery", d, 0);
    bus_write(9'h013, 8'h44); check("R11 write in recovery no busy", ctl_rdata[1], 0);
    idle(8);
    bus_read(9'h010, d, w); check("R3 programmed byte", d, 8'hA5);
    bus_read(9'h011, d, w); check("R5 write during busy dropped", d, 0);
    bus_read(9'h013, d, w); check("R11 write dropped", d, 0);
    bus_write(9'h010, 8'h3C); wait_idle(n);
    check("R3 busy length", n, PROG);
    idle(8);
    bus_read(9'h010, d, w); check("R3 whole byte replaced", d, 8'h3C);
    // R10
    ctl_write(8'h11); ext_irq_in = 1;
    bus_write(9'h020, 8'h77);
    hi = 0;
    repeat (PROG + 10) begin @(negedge clk); #2 if (irq_out) hi++; end
    check("R10 single pulse ext masked", hi, 1);
    ctl_write(8'h01); #1 check("R10 ext reconnected", irq_out, 1);
    ext_irq_in = 0;
    idle(2);
    // R6 / R7 / R8 / R9
    ctl_write(8'h05);
    bus_write(9'h043, 8'h11); bus_write(9'h04F, 8'h33); bus_write(9'h041, 8'h22);
    check("R6 latching no busy", ctl_rdata[1], 0);
    bus_write(9'h055, 8'h99);
    bus_read(9'h041, d, w); check("R8 read while parallel", d, 0);
    ctl_write(8'h0D); check("R7 start accepted", ctl_rdata, 8'h0F);
    wait_idle(n); check("R7 bits cleared at end", ctl_rdata, 8'h01);
    idle(8);
    bus_read(9'h041, d, w); check("R6 row byte 1", d, 8'h22);
    bus_read(9'h043, d, w); check("R6 row byte 3", d, 8'h11);
    bus_read(9'h04F, d, w); check("R6 row byte 15", d, 8'h33);
    bus_read(9'h042, d, w); check("R6 unlatched byte", d, 0);
    bus_read(9'h055, d, w); check("R9 foreign row ignored", d, 0);
    ctl_write(8'h09); check("R7 start refused without enable", ctl_rdata, 8'h01);
    // R8 abort
    bus_write(9'h060, 8'h0F); wait_idle(n); idle(8);
    ctl_write(8'h05); bus_write(9'h060, 8'hAA);
    ctl_write(8'h01); bus_read(9'h060, d, w);
    ctl_write(8'h05); ctl_write(8'h0D); wait_idle(n); idle(8);
    bus_read(9'h060, d, w); check("R8 latches discarded", d, 8'h0F);
    // R12
    ctl_write(8'h21); bus_write(9'h070, 8'h55);
    check("R12 no busy in standby", ctl_rdata[1], 0);
    bus_read(9'h010, d, w); check("R12 read in standby", d, 0);
    ctl_write(8'h01); bus_write(9'h071, 8'h66);
    check("R12 write in recovery dropped", ctl_rdata[1], 0);
    idle(8);
    bus_write(9'h070, 8'h5A); wait_idle(n); idle(8);
    bus_read(9'h070, d, w); check("R12 write after recovery", d, 8'h5A);
    bus_read(9'h071, d, w); check("R12 dropped byte", d, 0);
    // R13
    ctl_write(8'hC1); check("R13 verify stored bit7 zero", ctl_rdata, 8'h41);
    bus_read(9'h010, d, w); check("R13 verify no data effect", d, 8'h3C);
    idle(3);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule